// File: doc/BRIEF.md
# Line Range and Brown-Out Qualifier

This block turns four digitized line-voltage comparator flags into two qualified status flags for a power-factor controller: a line-range flag that tells high-line from low-line operation, and a line-good flag that tells whether the input voltage is high enough to run. The comparators sit outside the block, with their thresholds at about 95 V (start), 87 V (stop), 236 V (high-line entry) and 222 V (low-line entry). The block adds the timing on top of them.

The two directions of each flag are deliberately asymmetric. Entering high-line needs a short filter interval of steady high-line indication. Returning to low-line needs a much longer blanking interval of steady low-line indication. Every return to low-line also arms a lockout that forbids high-line re-entry until it runs out. The line-good flag sets at once when the start comparator trips. It clears only after the stop comparator has held for a long blanking interval. All intervals are parameters counted in clock ticks. Any break in a qualifying condition sends its timer back to zero.

Top module: `linebo_detector`

## Requirements
- R1: While reset is asserted and after its release, the range flag `high_line` is 0 (low-line) and `line_ok` is 0 (not good) until one of the rules below changes them.
- R2: In low-line with the lockout expired, `high_line` becomes 1 right after the HI_FILTER_TICKS-th consecutive rising clock edge at which `above_hi` is sampled 1.
- R3: A low sample of `above_hi` before the filter completes restarts the filter from zero. A burst shorter than HI_FILTER_TICKS edges leaves `high_line` at 0.
- R4: In high-line, `high_line` becomes 0 right after the LO_BLANK_TICKS-th consecutive edge at which `below_lo` is sampled 1. A low sample restarts that count.
- R5: Each high-to-low change starts a lockout of LOCK_TICKS edges. Filter counting for a new high-line entry starts only at the first edge after the lockout has run out, so with `above_hi` held, re-entry comes LOCK_TICKS + HI_FILTER_TICKS edges after the fall.
- R6: `above_hi` has no effect while in high-line, and `below_lo` has no effect while in low-line.
- R7: While `line_ok` is 0, one edge at which `above_bo_start` is sampled 1 sets `line_ok` to 1 at that edge. While `line_ok` is 1, `above_bo_start` has no effect.
- R8: While `line_ok` is 1, it clears right after the BO_BLANK_TICKS-th consecutive edge at which `below_bo_stop` is sampled 1. A low sample restarts that count.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| above_bo_start | input | 1 | Line above the brown-out start level |
| below_bo_stop | input | 1 | Line below the brown-out stop level |
| above_hi | input | 1 | Line above the high-line entry level |
| below_lo | input | 1 | Line below the low-line entry level |
| high_line | output | 1 | 1 = high-line range, 0 = low-line range |
| line_ok | output | 1 | 1 = line voltage good, 0 = brown-out |

## Verification
Each qualifier is first driven with bursts that are shorter than its interval and then with a steady level. This separates a timer that restarts on interruption from one that only pauses or counts cumulatively. The low-line indication is held past the fall while the high-line indication stays asserted. The re-entry edge is then compared against the lockout-plus-filter count, and a second re-entry with a late high-line indication shows the lockout ends rather than delays. Both brown-out comparators are asserted together so that the clear and the immediate re-set fall on adjacent edges. Every change of either output is matched against a predicted edge number, and any unpredicted change counts as an error.

// File: rtl/linebo_pkg.sv
package linebo_pkg;

  typedef enum logic {
    RANGE_LOW  = 1'b0,
    RANGE_HIGH = 1'b1
  } range_e;

  // Qualification is complete when this sample is the limit-th in a row.
  function automatic logic qual_reached(input int unsigned cnt,
                                        input int unsigned limit);
    return (cnt + 1 >= limit);
  endfunction

  // Next run length: zero on a break or on completion, else one more.
  function automatic int unsigned qual_next(input int unsigned cnt,
                                            input int unsigned limit,
                                            input logic        cond);
    if (!cond || qual_reached(cnt, limit))
      return 0;
    return cnt + 1;
  endfunction

  // Lockout down-counter: load on start, otherwise count toward zero.
  function automatic int unsigned lock_next(input int unsigned cnt,
                                            input int unsigned load_val,
                                            input logic        start);
    if (start)
      return load_val;
    if (cnt != 0)
      return cnt - 1;
    return 0;
  endfunction

endpackage

// File: rtl/linebo_qual.sv
module linebo_qual
  import linebo_pkg::*;
#(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic fire
);

  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [CW-1:0] run_q;

  assign fire = cond && qual_reached(32'(run_q), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else
      run_q <= CW'(qual_next(32'(run_q), LIMIT, cond));
  end

endmodule

// File: rtl/linebo_lockout.sv
module linebo_lockout
  import linebo_pkg::*;
#(
  parameter int unsigned LOCK_TICKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic locked
);

  generate
    if (LOCK_TICKS == 0) begin : g_none
      logic unused_lock_in;
      assign unused_lock_in = ^{clk, rst_n, start};
      assign locked = 1'b0;
    end else begin : g_count
      localparam int unsigned LW = $clog2(LOCK_TICKS + 1);
      logic [LW-1:0] left_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          left_q <= '0;
        else
          left_q <= LW'(lock_next(32'(left_q), LOCK_TICKS, start));
      end

      assign locked = (left_q != '0);
    end
  endgenerate

endmodule

// File: rtl/linebo_range.sv
module linebo_range
  import linebo_pkg::*;
#(
  parameter int unsigned HI_FILTER_TICKS = 8,
  parameter int unsigned LO_BLANK_TICKS  = 20,
  parameter int unsigned LOCK_TICKS      = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_hi,
  input  logic below_lo,
  output logic high_line,
  output logic hi_fire,
  output logic lo_fire,
  output logic locked
);

  range_e state_q;
  logic   up_cond;
  logic   dn_cond;

  assign up_cond = (state_q == RANGE_LOW) && above_hi && !locked;
  assign dn_cond = (state_q == RANGE_HIGH) && below_lo;

  linebo_qual #(.LIMIT(HI_FILTER_TICKS)) u_up_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .cond  (up_cond),
    .fire  (hi_fire)
  );

  linebo_qual #(.LIMIT(LO_BLANK_TICKS)) u_dn_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .cond  (dn_cond),
    .fire  (lo_fire)
  );

  linebo_lockout #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (lo_fire),
    .locked (locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= RANGE_LOW;
    else if (hi_fire)
      state_q <= RANGE_HIGH;
    else if (lo_fire)
      state_q <= RANGE_LOW;
  end

  assign high_line = (state_q == RANGE_HIGH);

endmodule

// File: rtl/linebo_brownout.sv
module linebo_brownout
  import linebo_pkg::*;
#(
  parameter int unsigned BO_BLANK_TICKS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_bo_start,
  input  logic below_bo_stop,
  output logic line_ok,
  output logic bo_drop
);

  logic ok_q;
  logic drop_cond;

  assign drop_cond = ok_q && below_bo_stop;

  linebo_qual #(.LIMIT(BO_BLANK_TICKS)) u_drop_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .cond  (drop_cond),
    .fire  (bo_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ok_q <= 1'b0;
    else if (!ok_q && above_bo_start)
      ok_q <= 1'b1;
    else if (bo_drop)
      ok_q <= 1'b0;
  end

  assign line_ok = ok_q;

endmodule

// File: rtl/linebo_detector.sv
module linebo_detector #(
  parameter int unsigned HI_FILTER_TICKS = 8,
  parameter int unsigned LO_BLANK_TICKS  = 20,
  parameter int unsigned LOCK_TICKS      = 40,
  parameter int unsigned BO_BLANK_TICKS  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_bo_start,
  input  logic below_bo_stop,
  input  logic above_hi,
  input  logic below_lo,
  output logic high_line,
  output logic line_ok
);

  logic hi_fire;
  logic lo_fire;
  logic locked;
  logic bo_drop;

  linebo_range #(
    .HI_FILTER_TICKS (HI_FILTER_TICKS),
    .LO_BLANK_TICKS  (LO_BLANK_TICKS),
    .LOCK_TICKS      (LOCK_TICKS)
  ) u_range (
    .clk       (clk),
    .rst_n     (rst_n),
    .above_hi  (above_hi),
    .below_lo  (below_lo),
    .high_line (high_line),
    .hi_fire   (hi_fire),
    .lo_fire   (lo_fire),
    .locked    (locked)
  );

  linebo_brownout #(
    .BO_BLANK_TICKS (BO_BLANK_TICKS)
  ) u_bo (
    .clk            (clk),
    .rst_n          (rst_n),
    .above_bo_start (above_bo_start),
    .below_bo_stop  (below_bo_stop),
    .line_ok        (line_ok),
    .bo_drop        (bo_drop)
  );

endmodule

// File: rtl/linebo_detector_chk.sv
module linebo_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic above_bo_start,
  input logic below_bo_stop,
  input logic above_hi,
  input logic below_lo,
  input logic high_line,
  input logic line_ok,
  input logic hi_fire,
  input logic lo_fire,
  input logic locked,
  input logic bo_drop
);

  // R2: entry to high-line follows a sampled high-line indication
  a_r2_rise_after_above: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(high_line) |-> $past(above_hi));

  // R2: a completed filter moves the range
  a_r2_fire_moves: assert property (@(posedge clk) disable iff (!rst_n)
    hi_fire |=> high_line);

  // R5: no entry while the lockout is still running
  a_r5_rise_not_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(high_line) |-> !$past(locked));

  // R4: return to low-line follows a sampled low-line indication
  a_r4_fall_after_below: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(high_line) |-> $past(below_lo));

  // R4: a completed blanking moves the range
  a_r4_fire_moves: assert property (@(posedge clk) disable iff (!rst_n)
    lo_fire |=> !high_line);

  // R6: only the qualifier of the current range can complete
  a_r6_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_fire, lo_fire}));

  // R7: immediate recovery from brown-out
  a_r7_ok_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_ok && above_bo_start) |=> line_ok);

  // R8: clearing follows a sampled stop indication
  a_r8_drop_after_below: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_ok) |-> $past(below_bo_stop));

  // R8: a completed blanking clears the flag
  a_r8_drop_moves: assert property (@(posedge clk) disable iff (!rst_n)
    bo_drop |=> !line_ok);

endmodule

bind linebo_detector linebo_detector_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .above_bo_start (above_bo_start),
  .below_bo_stop  (below_bo_stop),
  .above_hi       (above_hi),
  .below_lo       (below_lo),
  .high_line      (high_line),
  .line_ok        (line_ok),
  .hi_fire        (hi_fire),
  .lo_fire        (lo_fire),
  .locked         (locked),
  .bo_drop        (bo_drop)
);

// File: tb/test_linebo_detector.sv
module test_linebo_detector;

  localparam int HI_F = 8;
  localparam int LO_B = 20;
  localparam int LOCK = 40;
  localparam int BO_B = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above_bo_start = 1'b0;
  logic below_bo_stop = 1'b0;
  logic above_hi = 1'b0;
  logic below_lo = 1'b0;
  logic high_line;
  logic line_ok;

  always #2 clk = ~clk;

  linebo_detector #(
    .HI_FILTER_TICKS (HI_F),
    .LO_BLANK_TICKS  (LO_B),
    .LOCK_TICKS      (LOCK),
    .BO_BLANK_TICKS  (BO_B)
  ) i_linebo_detector (
    .clk            (clk),
    .rst_n          (rst_n),
    .above_bo_start (above_bo_start),
    .below_bo_stop  (below_bo_stop),
    .above_hi       (above_hi),
    .below_lo       (below_lo),
    .high_line      (high_line),
    .line_ok        (line_ok)
  );

  typedef struct {
    string req;
    bit    is_ok;
    bit    val;
    int    cyc;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   started = 0;
  bit   done = 0;
  logic prev_hl = 1'b0;
  logic prev_ok = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, cyc, act, expv);
    end
  endtask

  task automatic push(string req, bit is_ok, bit val, int at);
    exp_t e;
    e.req = req; e.is_ok = is_ok; e.val = val; e.cyc = at;
    exp_q.push_back(e);
  endtask

  task automatic on_change(bit is_ok, logic val);
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL unexpected change of %s at cycle %0d: actual=%b expected=no change",
               is_ok ? "line_ok" : "high_line", cyc, val);
    end else begin
      e = exp_q.pop_front();
      if (e.is_ok != is_ok || e.val != val || e.cyc != cyc) begin
        fails++;
        $display("FAIL %s: actual=%s->%b at cycle %0d expected=%s->%b at cycle %0d",
                 e.req, is_ok ? "line_ok" : "high_line", val, cyc,
                 e.is_ok ? "line_ok" : "high_line", e.val, e.cyc);
      end
    end
  endtask

  // Monitor: every output change must match the next predicted event.
  always @(negedge clk) begin
    if (started) begin
      if (high_line !== prev_hl) on_change(1'b0, high_line);
      if (line_ok !== prev_ok) on_change(1'b1, line_ok);
    end
    prev_hl = high_line;
    prev_ok = line_ok;
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int c;
    wait_n(3);
    chk("R1 high_line in reset", high_line, 1'b0);
    chk("R1 line_ok in reset", line_ok, 1'b0);
    rst_n = 1'b1;
    started = 1;
    wait_n(3);
    chk("R1 high_line after reset", high_line, 1'b0);

    // R7: immediate set
    @(negedge clk); c = cyc;
    above_bo_start = 1'b1;
    push("R7 set on start", 1'b1, 1'b1, c + 1);
    @(negedge clk); above_bo_start = 1'b0;
    wait_n(3);

    // R3: short burst does nothing
    @(negedge clk); above_hi = 1'b1;
    wait_n(HI_F - 3);
    above_hi = 1'b0;
    wait_n(10);
    chk("R3 short burst ignored", high_line, 1'b0);

    // R2: steady high-line entry
    @(negedge clk); c = cyc;
    above_hi = 1'b1;
    push("R2 filtered entry", 1'b0, 1'b1, c + HI_F);
    wait_n(HI_F + 4);
    chk("R2 in high-line", high_line, 1'b1);

    // R4 restart: short low-line burst, above_hi ignored in high (R6)
    @(negedge clk); below_lo = 1'b1;
    wait_n(LO_B / 2);
    below_lo = 1'b0;
    wait_n(5);
    chk("R4 short low burst ignored", high_line, 1'b1);

    // R4 fall, then R5 lockout with above_hi held
    @(negedge clk); c = cyc;
    below_lo = 1'b1;
    push("R4 blanked return", 1'b0, 1'b0, c + LO_B);
    push("R5 re-entry after lockout", 1'b0, 1'b1, c + LO_B + LOCK + HI_F);
    wait_n(LO_B + 20);
    chk("R5 still locked out", high_line, 1'b0);
    below_lo = 1'b0;   // below_lo was ignored in low-line (R6)
    wait_n(40);
    chk("R5 high after lockout", high_line, 1'b1);

    // R8 restart: short stop burst
    @(negedge clk); below_bo_stop = 1'b1;
    wait_n(BO_B / 2);
    below_bo_stop = 1'b0;
    wait_n(2);
    chk("R8 short stop burst ignored", line_ok, 1'b1);

    // R8 clear with start held (ignored while good), then R7 recovery
    @(negedge clk); c = cyc;
    below_bo_stop = 1'b1;
    above_bo_start = 1'b1;
    push("R8 blanked clear", 1'b1, 1'b0, c + BO_B);
    push("R7 immediate recovery", 1'b1, 1'b1, c + BO_B + 1);
    wait_n(BO_B + 5);
    below_bo_stop = 1'b0;
    above_bo_start = 1'b0;
    wait_n(5);
    chk("R7 good after recovery", line_ok, 1'b1);

    // R5 with late high-line indication after the lockout
    @(negedge clk); c = cyc;
    above_hi = 1'b0;
    below_lo = 1'b1;
    push("R4 second return", 1'b0, 1'b0, c + LO_B);
    wait_n(LO_B);
    below_lo = 1'b0;
    wait_n(LOCK + 20);
    chk("R5 low with no indication", high_line, 1'b0);
    @(negedge clk); c = cyc;
    above_hi = 1'b1;
    push("R2 entry after expired lockout", 1'b0, 1'b1, c + HI_F);
    wait_n(HI_F + 5);
    chk("R2 final high-line", high_line, 1'b1);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 pending events: actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (R1 sequence hung): actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule